// File: doc/BRIEF.md
# Disk Target Bus Phase Sequencer

This block is the target side of a parallel SCSI disk. It watches the bus for a selection aimed at it and takes the bus by raising its busy line. It then steps through the phases of one command: an optional message-out byte, the command bytes, a data transfer in either direction, a status byte and a closing message-in byte. It drives busy, request and the three phase lines (MSG, C/D, I/O). Each byte moves on a request/acknowledge handshake, except that data sent to the target uses a separate DMA request/acknowledge pair.

The block collects the command descriptor bytes and decodes four operations: READ(10), WRITE(10), INQUIRY and REQUEST SENSE. From the command fields it works out how many bytes to move and which block address to use. Media bytes pass through a byte port to an external block store. The port carries the block address, the byte index within the transfer, a write strobe with its data, and a read-data input that the store returns in the same cycle. Commands sent to a nonzero logical unit are answered with a check-condition status or with illegal-request sense data.

Top module: `scsi_target_seq`

## Requirements
- R1: After `rst_n` low, or in the cycle after `bus_rst` is seen high, `tgt_bsy`, `req`, `drq`, `msg`, `cd` and `io` are all 0 and the target is in bus free.
- R2: `tgt_bsy` rises only after a cycle in which `bus_bsy`=0, `bus_sel`=1, `data_i`≠0 and `sel_en`=1. If any one of these conditions is missing, the target does not take the bus.
- R3: After selection, the target enters message out ({msg,cd,io}=3'b110) if `bus_atn` was high, and command phase (3'b010) if it was low. A message-out byte moves the target to command phase.
- R4: `req` rises only at an edge where `bus_ack` is low. When `req` and `bus_ack` are both high, the byte is taken and `req` drops. `req` stays low while `bus_ack` stays high.
- R5: The number of command bytes is 10 when opcode bits 7:5 are 001 and 6 otherwise. No other phase starts before the last byte.
- R6: READ(10) (opcode 0x28) enters data in (3'b001) and returns (byte7·256+byte8)·512 bytes. `st_lba` = bytes 2..5 big-endian. Byte i equals `st_rdata` while `st_idx`=i.
- R7: WRITE(10) (opcode 0x2A) enters data out (3'b000) with `req` high. Each byte is taken on a `drq`/`bus_dack` handshake. `st_wr` is high with `st_wdata`=`data_i` and `st_idx`= the byte's index. After (byte7·256+byte8)·512 bytes the target enters status.
- R8: INQUIRY (0x12) returns byte4 bytes, all 0x00 except byte 2 = 0x02. If the LUN field (byte1 bits 7:5) is nonzero the status is 0x02, otherwise 0x00.
- R9: REQUEST SENSE (0x03) returns byte4 bytes with status 0x00. Byte 0 is 0x70. For a nonzero LUN, byte 2 = 0x05 and byte 12 = 0x08. All other bytes are 0x00.
- R10: Status phase (3'b011) presents the status byte. Message in (3'b111) presents the same byte. After the message-in byte is taken, `tgt_bsy` is 0 and the phase lines are 3'b000.
- R11: An opcode outside R6–R9, or a decoded transfer length of zero, goes straight from command to status with status 0x00.
- R12: `drq` is high only in data out (phase lines 3'b000 with `tgt_bsy` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset line |
| bus_bsy | input | 1 | Busy driven by other devices |
| bus_sel | input | 1 | Select line |
| bus_atn | input | 1 | Attention line |
| bus_ack | input | 1 | Initiator byte acknowledge |
| bus_dack | input | 1 | DMA acknowledge for data-out bytes |
| sel_en | input | 1 | Initiator select-enable control bit |
| data_i | input | 8 | Byte driven by the initiator |
| st_rdata | input | 8 | Store read byte for the current `st_lba`/`st_idx` |
| tgt_bsy | output | 1 | Target busy |
| req | output | 1 | Target byte request |
| drq | output | 1 | DMA request in data out |
| msg | output | 1 | Phase line MSG |
| cd | output | 1 | Phase line C/D |
| io | output | 1 | Phase line I/O |
| data_o | output | 8 | Byte presented to the initiator |
| st_lba | output | 32 | Block address of the transfer |
| st_idx | output | 25 | Byte index within the transfer |
| st_wr | output | 1 | Store write strobe |
| st_wdata | output | 8 | Store write byte |

## Verification
Most wrong internal states become visible at the very next request. A wrong phase register puts the wrong code on the phase lines. A wrong command-byte count lets a data or status request appear early, or keeps command requests coming after the last byte. An error in the length or index registers only appears at the end of a transfer or in the byte values: the status request arrives a byte early or late, or a store byte is read from or written to the wrong index. For this reason every transfer is counted byte by byte, and the phase change is checked at the exact request where it is due. A wrong status register shows up twice, in the status phase and again in message in.

// File: rtl/scsi_tgt_pkg.sv
// Shared types for the disk target sequencer.
// Assumes one target and a single outstanding command at a time.
package scsi_tgt_pkg;
    typedef enum logic [3:0] {
        PH_FREE, PH_ARB, PH_SEL, PH_MSGOUT, PH_CMD,
        PH_DIN, PH_DOUT, PH_STAT, PH_MSGIN
    } tgt_state_e;

    typedef enum logic [2:0] {
        CK_READ, CK_WRITE, CK_INQ, CK_SENSE, CK_OTHER
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SRC_STORE, SRC_INQ, SRC_SENSE
    } din_src_e;

    localparam int CDB_MAX = 10;

    localparam logic [7:0] OP_READ10  = 8'h28;
    localparam logic [7:0] OP_WRITE10 = 8'h2A;
    localparam logic [7:0] OP_INQ     = 8'h12;
    localparam logic [7:0] OP_SENSE   = 8'h03;

    localparam logic [7:0] STS_GOOD  = 8'h00;
    localparam logic [7:0] STS_CHECK = 8'h02;

    // phase line codes {msg, cd, io}
    localparam logic [2:0] LN_DOUT   = 3'b000;
    localparam logic [2:0] LN_DIN    = 3'b001;
    localparam logic [2:0] LN_CMD    = 3'b010;
    localparam logic [2:0] LN_STAT   = 3'b011;
    localparam logic [2:0] LN_MSGOUT = 3'b110;
    localparam logic [2:0] LN_MSGIN  = 3'b111;
endpackage

// File: rtl/scsi_cdb_decode.sv
// Command descriptor decoder: length by opcode group, operation kind,
// LUN check, transfer byte count and block address.
// Assumes the descriptor bytes are stable while being decoded (pure logic).
module scsi_cdb_decode
    import scsi_tgt_pkg::*;
#(
    parameter int BLK_W = 9
) (
    input  logic [CDB_MAX-1:0][7:0] cdb,
    output logic [3:0]              cdb_len,
    output cmd_kind_e               kind,
    output logic                    lun_nz,
    output logic [16+BLK_W-1:0]     xfer_len,
    output logic [31:0]             lba
);
    localparam int CNT_W = 16 + BLK_W;

    // Descriptor length from the opcode group field
    always_comb begin
        cdb_len = (cdb[0][7:5] == 3'b001) ? 4'd10 : 4'd6;
    end

    // Operation kind, LUN, byte count and big-endian block address
    always_comb begin
        lun_nz = (cdb[1][7:5] != 3'b000);
        lba    = {cdb[2], cdb[3], cdb[4], cdb[5]};
        unique case (cdb[0])
            OP_READ10:  kind = CK_READ;
            OP_WRITE10: kind = CK_WRITE;
            OP_INQ:     kind = CK_INQ;
            OP_SENSE:   kind = CK_SENSE;
            default:    kind = CK_OTHER;
        endcase
        case (kind)
            CK_READ, CK_WRITE: xfer_len = {cdb[7], cdb[8], {BLK_W{1'b0}}};
            CK_INQ, CK_SENSE:  xfer_len = {{(CNT_W-8){1'b0}}, cdb[4]};
            default:           xfer_len = '0;
        endcase
    end
endmodule

// File: rtl/scsi_din_mux.sv
// Selects the next data-in byte: store data, inquiry data or sense data.
// Assumes the store returns its byte in the same cycle as the index.
module scsi_din_mux
    import scsi_tgt_pkg::*;
#(
    parameter int CNT_W = 25
) (
    input  din_src_e         src,
    input  logic [CNT_W-1:0] idx,
    input  logic             sense_bad,
    input  logic [7:0]       st_rdata,
    output logic [7:0]       din_byte
);
    // Byte value for the current index and source
    always_comb begin
        din_byte = 8'h00;
        case (src)
            SRC_STORE: din_byte = st_rdata;
            SRC_INQ:   if (idx == CNT_W'(2)) din_byte = 8'h02;
            SRC_SENSE: begin
                if (idx == CNT_W'(0))                   din_byte = 8'h70;
                else if (sense_bad && idx == CNT_W'(2))  din_byte = 8'h05;
                else if (sense_bad && idx == CNT_W'(12)) din_byte = 8'h08;
            end
            default:   din_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/scsi_target_seq.sv
// Target-side bus phase sequencer for a minimal disk.
// Handles selection, message out, command collection, data in/out,
// status and message in. Phase lines are registered and change with
// the state. Assumes bus inputs are already synchronised to clk.
module scsi_target_seq
    import scsi_tgt_pkg::*;
#(
    parameter int BLK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              bus_bsy,
    input  logic              bus_sel,
    input  logic              bus_atn,
    input  logic              bus_ack,
    input  logic              bus_dack,
    input  logic              sel_en,
    input  logic [7:0]        data_i,
    input  logic [7:0]        st_rdata,
    output logic              tgt_bsy,
    output logic              req,
    output logic              drq,
    output logic              msg,
    output logic              cd,
    output logic              io,
    output logic [7:0]        data_o,
    output logic [31:0]       st_lba,
    output logic [16+BLK_W-1:0] st_idx,
    output logic              st_wr,
    output logic [7:0]        st_wdata
);
    localparam int CNT_W = 16 + BLK_W;

    tgt_state_e              state_q;
    logic                    bsy_q, req_q, drq_q;
    logic [2:0]              ln_q;
    logic [7:0]              dout_q, status_q;
    logic [3:0]              cnt_q;
    logic [CDB_MAX-1:0][7:0] cdb_q;
    logic [CNT_W-1:0]        remain_q, idx_q;
    logic [31:0]             lba_q;
    din_src_e                src_q;
    logic                    sense_bad_q;

    logic [3:0]              cdb_len;
    cmd_kind_e               kind;
    logic                    lun_nz;
    logic [CNT_W-1:0]        xfer_len;
    logic [31:0]             dec_lba;
    logic [7:0]              din_byte;
    logic                    dma_take;

    scsi_cdb_decode #(.BLK_W(BLK_W)) u_dec (
        .cdb      (cdb_q),
        .cdb_len  (cdb_len),
        .kind     (kind),
        .lun_nz   (lun_nz),
        .xfer_len (xfer_len),
        .lba      (dec_lba)
    );

    scsi_din_mux #(.CNT_W(CNT_W)) u_din (
        .src       (src_q),
        .idx       (idx_q),
        .sense_bad (sense_bad_q),
        .st_rdata  (st_rdata),
        .din_byte  (din_byte)
    );

    // DMA byte acceptance in data out
    assign dma_take = (state_q == PH_DOUT) && drq_q && bus_dack;

    // Phase sequencer, handshakes and transfer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            state_q     <= PH_FREE;
            bsy_q       <= 1'b0;
            req_q       <= 1'b0;
            drq_q       <= 1'b0;
            ln_q        <= LN_DOUT;
            dout_q      <= 8'h00;
            status_q    <= STS_GOOD;
            cnt_q       <= '0;
            cdb_q       <= '0;
            remain_q    <= '0;
            idx_q       <= '0;
            lba_q       <= '0;
            src_q       <= SRC_STORE;
            sense_bad_q <= 1'b0;
        end else begin
            case (state_q)
                PH_FREE: if (bus_sel) state_q <= PH_ARB;
                PH_ARB: begin
                    if (!bus_bsy && bus_sel && (data_i != 8'h00) && sel_en) begin
                        state_q <= PH_SEL;
                        bsy_q   <= 1'b1;
                    end else if (!bus_bsy && !bus_sel) begin
                        state_q <= PH_FREE;
                    end
                end
                PH_SEL: begin
                    status_q <= STS_GOOD;
                    cnt_q    <= '0;
                    if (bus_atn) begin
                        state_q <= PH_MSGOUT;
                        ln_q    <= LN_MSGOUT;
                    end else begin
                        state_q <= PH_CMD;
                        ln_q    <= LN_CMD;
                    end
                end
                PH_MSGOUT: begin
                    if (!bus_ack) req_q <= 1'b1;
                    else if (req_q) begin
                        req_q   <= 1'b0;
                        state_q <= PH_CMD;
                        ln_q    <= LN_CMD;
                    end
                end
                PH_CMD: begin
                    if (cnt_q == cdb_len) begin
                        lba_q       <= dec_lba;
                        idx_q       <= '0;
                        remain_q    <= xfer_len;
                        sense_bad_q <= lun_nz;
                        src_q       <= (kind == CK_INQ)   ? SRC_INQ :
                                       (kind == CK_SENSE) ? SRC_SENSE : SRC_STORE;
                        if (kind == CK_INQ && lun_nz) status_q <= STS_CHECK;
                        if (kind == CK_OTHER || xfer_len == '0) begin
                            state_q <= PH_STAT;
                            ln_q    <= LN_STAT;
                        end else if (kind == CK_WRITE) begin
                            state_q <= PH_DOUT;
                            ln_q    <= LN_DOUT;
                        end else begin
                            state_q <= PH_DIN;
                            ln_q    <= LN_DIN;
                        end
                    end else if (!bus_ack) begin
                        req_q <= 1'b1;
                    end else if (req_q) begin
                        cdb_q[cnt_q] <= data_i;
                        cnt_q        <= cnt_q + 4'd1;
                        req_q        <= 1'b0;
                    end
                end
                PH_DIN: begin
                    if (!bus_ack) begin
                        req_q  <= 1'b1;
                        dout_q <= din_byte;
                    end else if (req_q) begin
                        req_q    <= 1'b0;
                        idx_q    <= idx_q + CNT_W'(1);
                        remain_q <= remain_q - CNT_W'(1);
                        if (remain_q == CNT_W'(1)) begin
                            state_q <= PH_STAT;
                            ln_q    <= LN_STAT;
                        end
                    end
                end
                PH_DOUT: begin
                    if (!bus_ack) req_q <= 1'b1;
                    if (!bus_dack) drq_q <= 1'b1;
                    else if (drq_q) begin
                        drq_q    <= 1'b0;
                        idx_q    <= idx_q + CNT_W'(1);
                        remain_q <= remain_q - CNT_W'(1);
                        if (remain_q == CNT_W'(1)) begin
                            req_q   <= 1'b0;
                            state_q <= PH_STAT;
                            ln_q    <= LN_STAT;
                        end
                    end
                end
                PH_STAT: begin
                    if (!bus_ack) begin
                        req_q  <= 1'b1;
                        dout_q <= status_q;
                    end else if (req_q) begin
                        req_q   <= 1'b0;
                        state_q <= PH_MSGIN;
                        ln_q    <= LN_MSGIN;
                    end
                end
                PH_MSGIN: begin
                    if (!bus_ack) begin
                        req_q  <= 1'b1;
                        dout_q <= status_q;
                    end else if (req_q) begin
                        req_q   <= 1'b0;
                        bsy_q   <= 1'b0;
                        state_q <= PH_FREE;
                        ln_q    <= LN_DOUT;
                    end
                end
                default: state_q <= PH_FREE;
            endcase
        end
    end

    assign tgt_bsy  = bsy_q;
    assign req      = req_q;
    assign drq      = drq_q;
    assign {msg, cd, io} = ln_q;
    assign data_o   = dout_q;
    assign st_lba   = lba_q;
    assign st_idx   = idx_q;
    assign st_wr    = dma_take;
    assign st_wdata = data_i;

    // A bus reset clears every driven bus line
    assert_bus_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!bsy_q && !req_q && !drq_q && ln_q == LN_DOUT));

    // The target takes the bus only after a qualified selection
    assert_sel_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_q) |-> $past(!bus_bsy && bus_sel && data_i != 8'h00 && sel_en));

    // Request rises only at an edge where acknowledge was low
    assert_req_after_ack_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(!bus_ack));

    // Status and message-in requests carry their phase codes
    assert_status_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && state_q == PH_STAT) |-> (ln_q == LN_STAT));

    // Bus is released after the message-in byte
    assert_release_after_msgin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_MSGIN && req_q && bus_ack) |=> (!bsy_q && ln_q == LN_DOUT));

    // DMA request only while holding the bus in data out
    assert_drq_in_dout_R12: assert property (@(posedge clk) disable iff (!rst_n)
        drq_q |-> (bsy_q && ln_q == LN_DOUT));
endmodule

// File: tb/scsi_target_seq_tb.sv
module scsi_target_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 0, bus_bsy = 0, bus_sel = 0, bus_atn = 0, bus_ack = 0, bus_dack = 0, sel_en = 0;
    logic [7:0] data_i = 0;
    logic [7:0] st_rdata;
    logic tgt_bsy, req, drq, msg, cd, io, st_wr;
    logic [7:0] data_o, st_wdata;
    logic [31:0] st_lba;
    logic [24:0] st_idx;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] cq[$];

    always #5 clk = ~clk;

    // external store model: byte depends on address and index
    assign st_rdata = st_idx[7:0] ^ st_lba[7:0] ^ 8'h5A;

    scsi_target_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_bsy(bus_bsy),
        .bus_sel(bus_sel), .bus_atn(bus_atn), .bus_ack(bus_ack), .bus_dack(bus_dack),
        .sel_en(sel_en), .data_i(data_i), .st_rdata(st_rdata),
        .tgt_bsy(tgt_bsy), .req(req), .drq(drq), .msg(msg), .cd(cd), .io(io),
        .data_o(data_o), .st_lba(st_lba), .st_idx(st_idx), .st_wr(st_wr), .st_wdata(st_wdata)
    );

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a, input int i);
        return i[7:0] ^ a[7:0] ^ 8'h5A;
    endfunction

    // every clock: DMA request must mean data out with the bus held (R12)
    always @(negedge clk) begin
        cyc++;
        if (drq) chk(tgt_bsy && {msg, cd, io} == 3'b000, "R12", {tgt_bsy, msg, cd, io}, 4'b1000);
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_sig(input bit want_req, input bit level);
        for (int i = 0; i < 3000; i++) begin
            if ((want_req ? req : drq) == level) return;
            @(negedge clk);
        end
        chk(0, "timeout", 0, 1);
    endtask

    // one request/acknowledge byte exchange
    task automatic hs(input logic [7:0] b, output logic [7:0] got, output logic [2:0] ph);
        wait_sig(1, 1);
        ph = {msg, cd, io};
        got = data_o;
        data_i = b;
        bus_ack = 1;
        @(negedge clk);
        wait_sig(1, 0);
        bus_ack = 0;
    endtask

    task automatic do_select(input bit atn_v);
        @(negedge clk);
        bus_atn = atn_v; data_i = 8'h80; sel_en = 1; bus_sel = 1;
        for (int i = 0; i < 10 && !tgt_bsy; i++) @(negedge clk);
        chk(tgt_bsy == 1, "R2 select", tgt_bsy, 1);
        bus_sel = 0; data_i = 0;
    endtask

    task automatic send_cdb();
        logic [7:0] g; logic [2:0] ph;
        foreach (cq[k]) begin
            hs(cq[k], g, ph);
            chk(ph == 3'b010, $sformatf("R5 cmd byte %0d", k), ph, 3'b010);
        end
    endtask

    task automatic finish_cmd(input logic [7:0] exp);
        logic [7:0] g; logic [2:0] ph;
        hs(0, g, ph);
        chk(ph == 3'b011 && g == exp, "R10 status", {ph, g}, {3'b011, exp});
        hs(0, g, ph);
        chk(ph == 3'b111 && g == exp, "R10 msgin", {ph, g}, {3'b111, exp});
        @(negedge clk);
        chk(!tgt_bsy && {msg, cd, io} == 0, "R10 release", {tgt_bsy, msg, cd, io}, 0);
    endtask

    task automatic recv(input int n, input string r, output logic [7:0] d[$]);
        logic [7:0] g; logic [2:0] ph;
        d = {};
        for (int i = 0; i < n; i++) begin
            hs(0, g, ph);
            chk(ph == 3'b001, {r, " din phase"}, ph, 3'b001);
            d.push_back(g);
        end
    endtask

    initial begin
        logic [7:0] d[$];
        logic [7:0] g;
        logic [2:0] ph;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({tgt_bsy, req, drq, msg, cd, io} == 0, "R1 reset", {tgt_bsy, req, drq, msg, cd, io}, 0);

        // R2: missing qualifiers never take the bus
        bus_sel = 1; data_i = 8'h80; sel_en = 0;
        repeat (4) @(negedge clk);
        chk(!tgt_bsy, "R2 no sel_en", tgt_bsy, 0);
        sel_en = 1; data_i = 0;
        repeat (4) @(negedge clk);
        chk(!tgt_bsy, "R2 zero data", tgt_bsy, 0);
        data_i = 8'h80; bus_bsy = 1;
        repeat (4) @(negedge clk);
        chk(!tgt_bsy, "R2 bus busy", tgt_bsy, 0);
        bus_sel = 0; bus_bsy = 0; data_i = 0;
        repeat (3) @(negedge clk);

        // INQUIRY LUN 0 with message out (R3, R4, R5, R8)
        do_select(1);
        hs(8'h80, g, ph);
        chk(ph == 3'b110, "R3 msgout", ph, 3'b110);
        bus_atn = 0;
        wait_sig(1, 1);
        bus_ack = 1; data_i = 8'h12;
        @(negedge clk); @(negedge clk);
        chk(!req, "R4 req drops", req, 0);
        @(negedge clk);
        chk(!req, "R4 req held low while ack high", req, 0);
        bus_ack = 0;
        cq = '{8'h00, 8'h00, 8'h00, 8'h05, 8'h00};
        send_cdb();
        recv(5, "R8", d);
        foreach (d[k]) chk(d[k] == ((k == 2) ? 8'h02 : 8'h00), "R8 inquiry byte", d[k], (k == 2) ? 2 : 0);
        finish_cmd(8'h00);

        // INQUIRY nonzero LUN without attention (R3, R8)
        do_select(0);
        wait_sig(1, 1);
        chk({msg, cd, io} == 3'b010, "R3 cmd phase", {msg, cd, io}, 3'b010);
        cq = '{8'h12, 8'h20, 8'h00, 8'h00, 8'h03, 8'h00};
        send_cdb();
        recv(3, "R8", d);
        finish_cmd(8'h02);

        // REQUEST SENSE nonzero LUN (R9)
        do_select(0);
        cq = '{8'h03, 8'h40, 8'h00, 8'h00, 8'h0E, 8'h00};
        send_cdb();
        recv(14, "R9", d);
        foreach (d[k]) chk(d[k] == ((k == 0) ? 8'h70 : (k == 2) ? 8'h05 : (k == 12) ? 8'h08 : 8'h00),
                           "R9 sense byte", d[k], k);
        finish_cmd(8'h00);

        // REQUEST SENSE LUN 0 (R9)
        do_select(0);
        cq = '{8'h03, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00};
        send_cdb();
        recv(3, "R9", d);
        chk(d[0] == 8'h70 && d[1] == 0 && d[2] == 0, "R9 good sense", {d[0], d[1], d[2]}, 24'h700000);
        finish_cmd(8'h00);

        // READ(10) one block (R5, R6)
        do_select(0);
        cq = '{8'h28, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h00, 8'h01, 8'h00};
        send_cdb();
        recv(512, "R6", d);
        chk(st_lba == 32'h01020304, "R6 lba", st_lba, 32'h01020304);
        begin
            int bad = 0;
            foreach (d[k]) if (d[k] != mem_byte(32'h01020304, k)) bad++;
            chk(bad == 0 && d.size() == 512, "R6 read data", bad, 0);
        end
        finish_cmd(8'h00);

        // WRITE(10) one block over DMA (R7)
        do_select(0);
        cq = '{8'h2A, 8'h00, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h00, 8'h00, 8'h01, 8'h00};
        send_cdb();
        wait_sig(0, 1);
        chk(req && {msg, cd, io} == 3'b000, "R7 dout entry", {req, msg, cd, io}, 4'b1000);
        chk(st_lba == 32'h0A0B0C0D, "R7 lba", st_lba, 32'h0A0B0C0D);
        begin
            int bad = 0;
            for (int i = 0; i < 512; i++) begin
                wait_sig(0, 1);
                data_i = mem_byte(32'h0, i * 3);
                bus_dack = 1;
                #1;
                if (!(st_wr && st_wdata == data_i && st_idx == 25'(i))) begin
                    bad++;
                    $display("FAIL R7 write %0d actual=%0h/%0h expected=%0h/%0h", i, st_wdata, st_idx, data_i, i);
                end
                @(negedge clk);
                wait_sig(0, 0);
                bus_dack = 0;
            end
            chk(bad == 0, "R7 write bytes", bad, 0);
        end
        finish_cmd(8'h00);

        // unknown opcode and zero-length read go straight to status (R11)
        do_select(0);
        cq = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send_cdb();
        finish_cmd(8'h00);
        do_select(0);
        cq = '{8'h28, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00};
        send_cdb();
        finish_cmd(8'h00);

        // bus reset in the middle of a read (R1)
        do_select(0);
        cq = '{8'h28, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00};
        send_cdb();
        recv(3, "R6", d);
        bus_rst = 1;
        @(negedge clk);
        bus_rst = 0;
        chk({tgt_bsy, req, drq, msg, cd, io} == 0, "R1 bus reset", {tgt_bsy, req, drq, msg, cd, io}, 0);
        repeat (3) @(negedge clk);
        chk(!tgt_bsy && !req, "R1 stays free", {tgt_bsy, req}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule